// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Counter

This block is a 16-bit counter held as two byte-wide halves. It steps either on internal machine cycles of 12 system clocks or on falling edges of an external count pin. A control byte selects one of four behaviours: off, 16-bit capture, 16-bit auto-reload (counting up, or in either direction), or baud-rate generation. In capture mode the 16-bit reload register also serves as the capture register.

Software reaches the block through a byte-wide register port. The write side is synchronous. The read side is combinational. Two sticky flags report counter overflow and external events, and each is cleared by writing a one to it. In baud mode the block gives a one-clock tick on every wrap. Both external pins are sampled once per machine cycle at a fixed phase. For this reason an edge takes effect one clock after the machine cycle that detected it, and pin levels must be held for at least a machine cycle.

Top module: `mm_timer16`

## Requirements
- R1: After reset, both count bytes, both reload bytes, the control byte, both flags and the baud tick are all zero.
- R2: Register map: address 0 is the count low byte, 1 the count high byte, 2 the reload low byte, 3 the reload high byte, 4 control, and 5 status (bit 0 overflow, bit 1 event). Control bits are: 0 run, 1 external source, 2 capture select, 3 receive clock, 4 transmit clock, 5 trigger enable, 6 down enable, and 7 spare (stored). A count byte write lands in the clock it is made, and that clock's counting step is dropped.
- R3: Mode priority: with run at 0 the count holds. With run at 1 and either clock bit set, the block is a baud generator. Otherwise the capture select picks capture (1) or auto-reload (0).
- R4: With the external source at 0, the count advances once per machine cycle. A free-running 12-clock phase counter starts at reset release, so the count advances on the 12th, 24th, ... clock edge.
- R5: With the external source at 1, the count pin is sampled on the last clock of each machine cycle. A high sample followed by a low sample adds one, on the clock edge that follows the detecting sample. Pulses shorter than a machine cycle may be lost.
- R6: In auto-reload mode, a step at 0xFFFF loads the reload value and sets the overflow flag.
- R7: In auto-reload mode with down enable set, a low trigger pin counts down. A down step at a count equal to the reload value gives 0xFFFF, sets overflow and toggles the event flag. An up overflow also toggles the event flag.
- R8: In capture mode with trigger enable set, a trigger falling edge copies the count before that clock's step into the reload register and sets the event flag. The copy takes precedence over a software reload write. The count keeps running and wraps from 0xFFFF to 0, setting overflow.
- R9: In baud mode the count steps every 2 clocks, whatever the source bit says. A step at 0xFFFF loads the reload value and drives the baud tick high for the next clock. The overflow flag is left alone.
- R10: Flags stay set until a one is written to their status bit. A set or toggle in the same clock as a clear is applied after the clear.
- R11: Trigger edges outside capture mode, or with trigger enable at 0, leave the reload register and the event flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_cnt_i | input | 1 | External count pin |
| ext_trig_i | input | 1 | External capture trigger / count direction pin |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| evt_flag_o | output | 1 | Sticky external-event flag |
| baud_tick_o | output | 1 | One-clock pulse on each baud-mode wrap |

## Verification
The count and trigger pins use the same sampling edge. In external-count capture mode, a falling edge on both pins therefore produces a count step and a capture in the same clock. The bench causes this by driving both pins low together, with the count set a few values below 0xFFFF, so that the capture also coincides with an overflow. A behavioural model compares all six registers and both flags on every clock. The captured value must equal the count before the step, and the count must still advance. Status clears are also written on every other clock while overflows fire each machine cycle, so that set and clear collide.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  localparam int unsigned HALF_W = 8;
  localparam int unsigned CNT_W  = 2 * HALF_W;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_RLD_LO = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_RLD_HI = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(5);

  typedef enum logic [1:0] {MD_OFF, MD_CAPT, MD_ARL, MD_BAUD} mode_e;

  typedef struct packed {
    logic spare;
    logic down_en;
    logic trig_en;
    logic tx_clk;
    logic rx_clk;
    logic cap_sel;
    logic ext_sel;
    logic run;
  } ctrl_t;

  function automatic mode_e decode_mode(ctrl_t c);
    if (!c.run) return MD_OFF;
    if (c.rx_clk || c.tx_clk) return MD_BAUD;
    return c.cap_sel ? MD_CAPT : MD_ARL;
  endfunction

  function automatic logic [CNT_W-1:0] put_half(logic [CNT_W-1:0] v, logic hi,
                                                logic [HALF_W-1:0] b);
    logic [CNT_W-1:0] r;
    r = v;
    if (hi) r[CNT_W-1:HALF_W] = b;
    else    r[HALF_W-1:0]     = b;
    return r;
  endfunction

  function automatic logic [HALF_W-1:0] get_half(logic [CNT_W-1:0] v, logic hi);
    return hi ? v[CNT_W-1:HALF_W] : v[HALF_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] bump(logic [CNT_W-1:0] v, logic down);
    return down ? (v - CNT_W'(1)) : (v + CNT_W'(1));
  endfunction
endpackage

// File: rtl/mmt_timebase.sv
module mmt_timebase #(
  parameter int unsigned MC_CLKS  = 12,
  parameter int unsigned BAUD_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic mc_tick,
  output logic baud_step
);
  localparam int unsigned PH_W = (MC_CLKS > 1) ? $clog2(MC_CLKS) : 1;
  localparam int unsigned BD_W = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(MC_CLKS - 1);
  localparam logic [BD_W-1:0] BD_LAST = BD_W'(BAUD_DIV - 1);

  logic [PH_W-1:0] ph_q;
  logic [BD_W-1:0] bd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      bd_q <= '0;
    end else begin
      ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      bd_q <= (bd_q == BD_LAST) ? '0 : bd_q + 1'b1;
    end
  end

  assign mc_tick   = (ph_q == PH_LAST);
  assign baud_step = (bd_q == BD_LAST);

  // R4: machine-cycle ticks never come back to back
  p_mc_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mc_tick |=> !mc_tick);
endmodule

// File: rtl/mmt_fall_smp.sv
module mmt_fall_smp (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic pin,
  output logic fall_o
);
  logic last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      fall_o <= smp_en & last_q & ~pin;
      if (smp_en) last_q <= pin;
    end
  end

  // R5: an edge pulse only follows a sampling clock
  p_fall_after_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> $past(smp_en));
  // R5: an edge pulse lasts one clock
  p_fall_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/mmt_core.sv
module mmt_core
  import mmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_tick,
  input  logic              baud_step,
  input  logic              ext_fall,
  input  logic              trig_fall,
  input  logic              trig_lvl,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [HALF_W-1:0] rd_data,
  output logic              ovf_flag,
  output logic              evt_flag,
  output logic              baud_tick
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q, rld_q, cnt_nx;
  logic             ovf_q, evt_q, tick_q;
  mode_e            mode;

  // named internal events
  logic cnt_wr, rld_wr, stat_wr, src_step, do_step, go_down, at_top, at_floor;
  logic wrap_evt, ovf_set, evt_tgl, cap_evt, baud_wrap;

  assign mode     = decode_mode(ctrl_q);
  assign cnt_wr   = wr_en && (wr_addr == A_CNT_LO || wr_addr == A_CNT_HI);
  assign rld_wr   = wr_en && (wr_addr == A_RLD_LO || wr_addr == A_RLD_HI);
  assign stat_wr  = wr_en && (wr_addr == A_STAT);
  assign src_step = (mode == MD_BAUD) ? baud_step : (ctrl_q.ext_sel ? ext_fall : mc_tick);
  assign do_step  = (mode != MD_OFF) && src_step && !cnt_wr;
  assign go_down  = (mode == MD_ARL) && ctrl_q.down_en && !trig_lvl;
  assign at_top   = &cnt_q;
  assign at_floor = (cnt_q == rld_q);
  assign wrap_evt = do_step && (go_down ? at_floor : at_top);
  assign ovf_set  = wrap_evt && (mode != MD_BAUD);
  assign baud_wrap = wrap_evt && (mode == MD_BAUD);
  assign evt_tgl  = wrap_evt && (mode == MD_ARL) && ctrl_q.down_en;
  assign cap_evt  = (mode == MD_CAPT) && ctrl_q.trig_en && trig_fall;

  always_comb begin
    if (cnt_wr)                             cnt_nx = put_half(cnt_q, wr_addr == A_CNT_HI, wr_data);
    else if (!do_step)                      cnt_nx = cnt_q;
    else if (go_down && at_floor)           cnt_nx = '1;
    else if (go_down)                       cnt_nx = bump(cnt_q, 1'b1);
    else if (at_top && mode != MD_CAPT)     cnt_nx = rld_q;
    else                                    cnt_nx = bump(cnt_q, 1'b0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      rld_q  <= '0;
      ovf_q  <= 1'b0;
      evt_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      tick_q <= baud_wrap;
      if (wr_en && wr_addr == A_CTRL) ctrl_q <= ctrl_t'(wr_data);
      if (cap_evt)     rld_q <= cnt_q;
      else if (rld_wr) rld_q <= put_half(rld_q, wr_addr == A_RLD_HI, wr_data);
      ovf_q <= (ovf_q & ~(stat_wr & wr_data[0])) | ovf_set;
      evt_q <= ((evt_q & ~(stat_wr & wr_data[1])) | cap_evt) ^ evt_tgl;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CNT_LO: rd_data = get_half(cnt_q, 1'b0);
      A_CNT_HI: rd_data = get_half(cnt_q, 1'b1);
      A_RLD_LO: rd_data = get_half(rld_q, 1'b0);
      A_RLD_HI: rd_data = get_half(rld_q, 1'b1);
      A_CTRL:   rd_data = ctrl_q;
      A_STAT:   rd_data = {{(HALF_W-2){1'b0}}, evt_q, ovf_q};
      default:  rd_data = '0;
    endcase
  end

  assign ovf_flag  = ovf_q;
  assign evt_flag  = evt_q;
  assign baud_tick = tick_q;

  // R2: a count low-byte write lands regardless of counting
  p_write_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CNT_LO) |=> (cnt_q[HALF_W-1:0] == $past(wr_data)));
  // R3: count holds while the block is off
  p_off_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_OFF && !cnt_wr) |=> $stable(cnt_q));
  // R7: a down wrap gives all ones and sets overflow
  p_down_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && go_down && at_floor) |=> ((&cnt_q) && ovf_q));
  // R8: capture stores the pre-step count and raises the event flag
  p_capture_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (rld_q == $past(cnt_q) && evt_q));
  // R9: baud mode never raises overflow
  p_baud_no_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_BAUD && !ovf_q) |=> !ovf_q);
  // R9: a tick only follows a clock spent in baud mode
  p_tick_in_baud_r9: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> $past(mode == MD_BAUD));
  // R10: overflow stays set until cleared
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(stat_wr && wr_data[0])) |=> ovf_q);
endmodule

// File: rtl/mm_timer16.sv
module mm_timer16
  import mmt_pkg::*;
#(
  parameter int unsigned MC_CLKS  = 12,
  parameter int unsigned BAUD_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_cnt_i,
  input  logic              ext_trig_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [HALF_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [HALF_W-1:0] rd_data_o,
  output logic              ovf_flag_o,
  output logic              evt_flag_o,
  output logic              baud_tick_o
);
  localparam int unsigned NPIN = 2;

  logic            mc_tick, baud_step;
  logic [NPIN-1:0] pin_v, fall_v;

  assign pin_v = {ext_trig_i, ext_cnt_i};

  mmt_timebase #(.MC_CLKS(MC_CLKS), .BAUD_DIV(BAUD_DIV)) u_tb (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .baud_step(baud_step));

  for (genvar g = 0; g < NPIN; g++) begin : g_smp
    mmt_fall_smp u_smp (
      .clk(clk), .rst_n(rst_n), .smp_en(mc_tick), .pin(pin_v[g]), .fall_o(fall_v[g]));
  end

  mmt_core u_core (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .baud_step(baud_step),
    .ext_fall(fall_v[0]), .trig_fall(fall_v[1]), .trig_lvl(ext_trig_i),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .rd_addr(rd_addr_i), .rd_data(rd_data_o),
    .ovf_flag(ovf_flag_o), .evt_flag(evt_flag_o), .baud_tick(baud_tick_o));
endmodule

// File: tb/test_mm_timer16.sv
module test_mm_timer16;
  localparam int CLK_P = 20;

  logic       clk = 0, rst_n = 0;
  logic       ext_cnt = 0, ext_trig = 0, wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr;
  logic [7:0] wr_data = 0, rd_data;
  logic       ovf_flag, evt_flag, baud_tick;

  int checks = 0, errors = 0;
  bit chk_on = 0, done = 0;
  string cur_req = "R1";

  // reference model state
  int m_ph, m_bd, m_cnt, m_rld;
  bit [7:0] m_ctl;
  bit m_ovf, m_evt, m_btk, m_el, m_tl, m_ep, m_tp;

  mm_timer16 i_mm_timer16 (
    .clk(clk), .rst_n(rst_n), .ext_cnt_i(ext_cnt), .ext_trig_i(ext_trig),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .ovf_flag_o(ovf_flag), .evt_flag_o(evt_flag), .baud_tick_o(baud_tick));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model, one update per clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_bd = 0; m_cnt = 0; m_rld = 0; m_ctl = 0;
      m_ovf = 0; m_evt = 0; m_btk = 0; m_el = 0; m_tl = 0; m_ep = 0; m_tp = 0;
    end else begin
      bit tick, bstep, run, baud, capm, arl, src, cw, stp, down;
      int ncnt, nrld; bit novf, nevt, nbtk, nep, ntp, nel, ntl;
      tick = (m_ph == 11); bstep = (m_bd == 1);
      run = m_ctl[0]; baud = run && (m_ctl[3] || m_ctl[4]);
      capm = run && !baud && m_ctl[2]; arl = run && !baud && !m_ctl[2];
      src = baud ? bstep : (m_ctl[1] ? m_ep : tick);
      cw = wr_en && (wr_addr == 0 || wr_addr == 1);
      stp = run && src && !cw;
      down = arl && m_ctl[6] && !ext_trig;
      ncnt = m_cnt; nrld = m_rld; novf = m_ovf; nevt = m_evt; nbtk = 0;
      if (wr_en && wr_addr == 5) begin
        if (wr_data[0]) novf = 0;
        if (wr_data[1]) nevt = 0;
      end
      if (cw) begin
        if (wr_addr == 0) ncnt = (m_cnt & 'hFF00) | wr_data;
        else ncnt = (m_cnt & 'h00FF) | (int'(wr_data) << 8);
      end else if (stp) begin
        if (down) begin
          if (m_cnt == m_rld) begin ncnt = 'hFFFF; novf = 1; nevt = !nevt; end
          else ncnt = m_cnt - 1;
        end else if (m_cnt == 'hFFFF) begin
          if (baud) begin ncnt = m_rld; nbtk = 1; end
          else if (capm) begin ncnt = 0; novf = 1; end
          else begin ncnt = m_rld; novf = 1; if (m_ctl[6]) nevt = !nevt; end
        end else ncnt = m_cnt + 1;
      end
      if (wr_en && wr_addr == 2) nrld = (m_rld & 'hFF00) | wr_data;
      if (wr_en && wr_addr == 3) nrld = (m_rld & 'h00FF) | (int'(wr_data) << 8);
      if (capm && m_ctl[5] && m_tp) begin nrld = m_cnt; nevt = 1; end
      if (wr_en && wr_addr == 4) m_ctl = wr_data;
      nep = 0; ntp = 0; nel = m_el; ntl = m_tl;
      if (tick) begin
        nep = m_el && !ext_cnt; nel = ext_cnt;
        ntp = m_tl && !ext_trig; ntl = ext_trig;
      end
      m_cnt = ncnt; m_rld = nrld; m_ovf = novf; m_evt = nevt; m_btk = nbtk;
      m_ep = nep; m_tp = ntp; m_el = nel; m_tl = ntl;
      m_ph = (m_ph + 1) % 12; m_bd = (m_bd + 1) % 2;
    end
  end

  function automatic int exp_byte(int a);
    case (a)
      0: return m_cnt & 'hFF;
      1: return (m_cnt >> 8) & 'hFF;
      2: return m_rld & 'hFF;
      3: return (m_rld >> 8) & 'hFF;
      4: return int'(m_ctl);
      default: return {m_evt, m_ovf};
    endcase
  endfunction

  // per-clock comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      for (int a = 0; a < 6; a++) begin
        rd_addr = 3'(a);
        #1;
        check(cur_req, int'(rd_data), exp_byte(a));
      end
      check(cur_req, int'(ovf_flag), int'(m_ovf));
      check(cur_req, int'(evt_flag), int'(m_evt));
      check(cur_req, int'(baud_tick), int'(m_btk));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(bit e, bit t);
    @(negedge clk); #1;
    ext_cnt = e; ext_trig = t;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    #1 rst_n = 1;
    // R1: literal reset values
    @(negedge clk);
    for (int a = 0; a < 6; a++) begin
      rd_addr = 3'(a); #1;
      check("R1", int'(rd_data), 0);
    end
    check("R1", int'(ovf_flag), 0);
    check("R1", int'(evt_flag), 0);
    check("R1", int'(baud_tick), 0);
    chk_on = 1;

    cur_req = "R2";
    wr(2, 'h34); wr(3, 'h12); wr(0, 'hCD); wr(1, 'hAB); wr(4, 'h80);
    idle(4);

    cur_req = "R4";
    wr(0, 0); wr(1, 0); wr(4, 'h01);
    idle(130);
    cur_req = "R2";  // count writes while counting
    for (int i = 0; i < 14; i++) wr(0, 'h10 + i);

    cur_req = "R5";
    wr(4, 'h03); wr(0, 0);
    for (int i = 0; i < 4; i++) begin pins(1, 0); idle(30); pins(0, 0); idle(30); end
    for (int i = 0; i < 6; i++) begin pins(1, 0); idle(12); pins(0, 0); idle(12); end
    for (int i = 0; i < 6; i++) begin pins(1, 0); idle(4); pins(0, 0); idle(9); end
    pins(0, 0);

    cur_req = "R6";
    wr(4, 'h00); wr(2, 'hF0); wr(3, 'hFF); wr(0, 'hFA); wr(1, 'hFF); wr(4, 'h01);
    idle(220);

    cur_req = "R7";
    wr(4, 'h00); wr(5, 3); wr(2, 5); wr(3, 0); wr(0, 8); wr(1, 0);
    pins(0, 0); wr(4, 'h41);
    idle(100);
    wr(0, 'hFD); wr(1, 'hFF); pins(0, 1);
    idle(80);
    pins(0, 0);

    cur_req = "R8";
    wr(4, 'h00); wr(5, 3); wr(0, 'hF0); wr(1, 'hFF); wr(4, 'h25);
    for (int i = 0; i < 3; i++) begin pins(0, 1); idle(30); pins(0, 0); idle(30); end
    // coinciding count step, capture and overflow
    wr(4, 'h00); wr(0, 'hFD); wr(1, 'hFF); wr(4, 'h27);
    for (int i = 0; i < 5; i++) begin pins(1, 1); idle(24); pins(0, 0); idle(24); end
    // capture against a software reload write
    pins(1, 1); idle(24); pins(0, 0);
    for (int i = 0; i < 14; i++) wr(2, 'h55);

    cur_req = "R9";
    wr(4, 'h00); wr(5, 3); wr(2, 'hF8); wr(3, 'hFF); wr(0, 'hF8); wr(1, 'hFF); wr(4, 'h09);
    idle(60);
    wr(4, 'h13);
    for (int i = 0; i < 3; i++) begin pins(1, 0); idle(12); pins(0, 0); idle(12); end

    cur_req = "R3";
    wr(4, 'h0D); idle(40);
    wr(4, 'h1C); idle(40);
    wr(4, 'h05); idle(40);

    cur_req = "R10";
    wr(4, 'h00); wr(2, 'hFF); wr(3, 'hFF); wr(0, 'hFF); wr(1, 'hFF);
    pins(0, 1); wr(4, 'h41);
    for (int i = 0; i < 40; i++) wr(5, 3);
    idle(30);
    wr(5, 1); idle(5); wr(5, 2); idle(5);

    cur_req = "R11";
    wr(4, 'h00); wr(5, 3); wr(2, 'h22); wr(3, 'h11); wr(4, 'h21);
    for (int i = 0; i < 3; i++) begin pins(0, 1); idle(24); pins(0, 0); idle(24); end
    wr(4, 'h05);
    for (int i = 0; i < 3; i++) begin pins(0, 1); idle(24); pins(0, 0); idle(24); end
    idle(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule